// File: doc/BRIEF.md
# Cascaded Two-Core DMA Request Arbiter

This block picks which DMA channel may use the transfer engine next. There are eight channel slots in two cores of four. The lower core serves channels 0 to 3. The upper core serves channels 4 to 7. Slot 4 is not a requester of its own: it is the path by which the lower core's winner reaches the upper core. That leaves seven channels that can raise requests. Any request source can drive a channel line, whether an external pin or an on-chip serial-port source.

When the block is idle, it registers one grant. The grant appears as a one-hot acknowledge, the 3-bit number of the winning channel and a busy flag. The grant stays in place until the transfer engine pulses `done_i`.

Software sets up the block through a small write port. That port holds a mask bit for each channel and a cascade enable for slot 4. The lower core can be granted only while slot 4 is in cascade mode and unmasked. Any other setting of slot 4 silently blocks channels 0 to 3.

Top module: `dma_casc_arb`

## Requirements
- R1: After reset every mask bit is 1, cascade mode is off, `ack_o` is 0, `busy_o` is 0 and `chan_o` is 0. No grant is issued until the configuration allows one.
- R2: Configuration writes take effect at the clock edge where `cfg_we_i` is 1, and `cfg_op_i` selects the operation:
  - 0: set or clear one mask bit. `cfg_data_i[2:0]` is the channel and `cfg_data_i[3]` is the new value.
  - 1: load all eight mask bits from `cfg_data_i[7:0]`, where bit n is channel n.
  - 2: set cascade mode to `cfg_data_i[0]`.
  - 3: no effect.
- R3: Among the eligible requests, the lowest channel number wins. Because slot 4 ranks first in the upper core, any eligible channel 0 to 3 beats channels 5 to 7.
- R4: Channels 0 to 3 are eligible only while cascade mode is 1 and mask bit 4 is 0. `req_i[4]` has no effect in any mode.
- R5: When the block is idle and an eligible request is present at a clock edge, the grant appears at that edge. The grant then holds, unchanged, until an edge that sees `done_i` high. That edge clears it, and the earliest new grant comes at the edge after.
- R6: A channel whose mask bit is 1 is never granted. Masking the granted channel, or dropping its request, does not end the current grant.
- R7: `ack_o` has at most one bit set. While `busy_o` is 1, `ack_o` is set at bit `chan_o`, and `chan_o` is never 4. While idle, `chan_o` is 0.
- R8: A configuration write and a grant decision at the same edge are both performed. The grant decision uses the settings from before that write.
- R9: `done_i` has no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request line per channel; bit 4 unused |
| done_i | input | 1 | Transfer engine: current transfer finished |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | Configuration operation select |
| cfg_data_i | input | 8 | Configuration write data |
| ack_o | output | 8 | One-hot acknowledge of the granted channel |
| chan_o | output | 3 | Number of the granted channel |
| busy_o | output | 1 | A grant is active |

## Verification
Two things can land on the same edge: a configuration write and a grant decision. Examples are unmasking a channel while it requests, and masking the granted channel while `done_i` ends its transfer. The bench provokes these collisions with directed cases and with random traffic where writes, requests and `done_i` overlap freely. A behavioural model applies the rule "decide with the old settings, then apply the write" and is compared against the outputs on every cycle. Where a collision could let a new setting leak into the decision, the directed checks state the expected grant outright.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    CFG_MASK_BIT = 2'd0,
    CFG_MASK_ALL = 2'd1,
    CFG_CASC     = 2'd2,
    CFG_RSVD     = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    vld_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dma_arb_cfg.sv
module dma_arb_cfg
  import dma_arb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CIW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  cfg_op_e        op_i,
  input  logic [NCH-1:0] data_i,
  output logic [NCH-1:0] mask_o,
  output logic           casc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      casc_o <= 1'b0;
    end else if (we_i) begin
      unique case (op_i)
        CFG_MASK_BIT: mask_o[data_i[CIW-1:0]] <= data_i[CIW];
        CFG_MASK_ALL: mask_o <= data_i;
        CFG_CASC:     casc_o <= data_i[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_casc_arb.sv
module dma_casc_arb
  import dma_arb_pkg::*;
#(
  parameter int CPC = 4,
  localparam int NCH = 2 * CPC,
  localparam int CIW = $clog2(NCH),
  localparam int SIW = $clog2(CPC)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic           done_i,
  input  logic           cfg_we_i,
  input  logic [1:0]     cfg_op_i,
  input  logic [NCH-1:0] cfg_data_i,
  output logic [NCH-1:0] ack_o,
  output logic [CIW-1:0] chan_o,
  output logic           busy_o
);
  logic [NCH-1:0] mask;
  logic           casc;
  logic [CPC-1:0] s_req, m_req;
  logic           s_vld, m_vld;
  logic [SIW-1:0] s_idx, m_idx;
  logic [CIW-1:0] win;
  logic           unused_link_req;

  assign unused_link_req = req_i[CPC];

  dma_arb_cfg #(.NCH(NCH), .CIW(CIW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .op_i   (cfg_op_e'(cfg_op_i)),
    .data_i (cfg_data_i),
    .mask_o (mask),
    .casc_o (casc)
  );

  assign s_req = req_i[CPC-1:0] & ~mask[CPC-1:0];

  dma_prio_pick #(.N(CPC)) u_slave (.req_i(s_req), .vld_o(s_vld), .idx_o(s_idx));

  // slot 0 of the master core is the cascade link
  assign m_req[0] = s_vld & casc & ~mask[CPC];
  assign m_req[CPC-1:1] = req_i[NCH-1:CPC+1] & ~mask[NCH-1:CPC+1];

  dma_prio_pick #(.N(CPC)) u_master (.req_i(m_req), .vld_o(m_vld), .idx_o(m_idx));

  assign win = (m_idx == '0) ? CIW'(s_idx) : CIW'(CPC) + CIW'(m_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      chan_o <= '0;
      ack_o  <= '0;
    end else if (busy_o) begin
      if (done_i) begin
        busy_o <= 1'b0;
        chan_o <= '0;
        ack_o  <= '0;
      end
    end else if (m_vld) begin
      busy_o <= 1'b1;
      chan_o <= win;
      ack_o  <= NCH'(1) << win;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o)); // R7
  AST_ACK_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ack_o == (NCH'(1) << chan_o)) && (chan_o != CIW'(CPC))); // R7
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> busy_o && $stable(chan_o)); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i) |=> !busy_o); // R5
  AST_SLAVE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && chan_o < CIW'(CPC)) |-> $past(casc && !mask[CPC])); // R4
  AST_NO_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ((($past(mask) >> chan_o) & NCH'(1)) == '0)); // R6
endmodule

// File: tb/dma_casc_arb_bench.sv
module dma_casc_arb_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       done = 1'b0;
  logic       we = 1'b0;
  logic [1:0] op = '0;
  logic [7:0] wd = '0;
  logic [7:0] ack;
  logic [2:0] chan;
  logic       busy;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_casc_arb u_dma_casc_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .cfg_we_i(we), .cfg_op_i(op), .cfg_data_i(wd),
    .ack_o(ack), .chan_o(chan), .busy_o(busy)
  );

  // behavioural reference: decide with old settings, then apply write
  logic [7:0] m_mask;
  logic       m_casc;
  logic       m_busy;
  int         m_ch;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 8'hFF; m_casc = 1'b0; m_busy = 1'b0; m_ch = 0;
    end else begin
      if (m_busy) begin
        if (done) begin m_busy = 1'b0; m_ch = 0; end
      end else begin
        for (int c = 0; c < 8; c++)
          if (!m_busy && c != 4 && req[c] && !m_mask[c] &&
              (c > 4 || (m_casc && !m_mask[4]))) begin
            m_busy = 1'b1; m_ch = c;
          end
      end
      if (we) case (op)
        2'd0: m_mask[wd[2:0]] = wd[3];
        2'd1: m_mask = wd;
        2'd2: m_casc = wd[0];
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(ack == (m_busy ? 8'(1) << m_ch : 8'h00), "R3 ack vs model", ack, m_busy ? 1 << m_ch : 0);
    check(busy == m_busy, "R5 busy vs model", busy, m_busy);
    check(chan == 3'(m_ch), "R7 chan vs model", chan, m_ch);
  end

  task automatic drive(input logic [7:0] r, input logic d, input logic w,
                       input logic [1:0] o, input logic [7:0] dat);
    req = r; done = d; we = w; op = o; wd = dat;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R5 watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    tick();
    check(ack == 0 && busy == 0 && chan == 0, "R1 reset outputs", {busy, ack}, 0);
    tick();
    rst_n = 1'b1;
    drive(8'hFF, 0, 0, 0, 0);
    tick(); tick(); tick();
    check(busy == 0, "R1 no grant after reset", busy, 0);

    // R8: unmask ch5 in the same cycle as its request
    drive(8'h20, 0, 1, 2'd0, 8'h05);
    tick();
    check(busy == 0, "R8 decision uses old mask", busy, 0);
    drive(8'h20, 0, 0, 0, 0);
    tick();
    check(busy == 1 && chan == 5, "R5 grant ch5", chan, 5);
    // hold, then mask ch5 while granted
    drive(8'h00, 0, 1, 2'd0, 8'h0D);
    tick();
    drive(8'h00, 0, 0, 0, 0);
    tick(); tick();
    check(busy == 1 && chan == 5 && ack == 8'h20, "R6 grant held after mask", ack, 8'h20);
    drive(8'h20, 1, 0, 0, 0);
    tick();
    check(busy == 0, "R5 done clears grant", busy, 0);
    drive(8'h20, 0, 0, 0, 0);
    tick(); tick();
    check(busy == 0, "R6 masked ch5 ignored", busy, 0);

    // unmask all, cascade still off: slave channels blocked
    drive(8'h1F, 0, 1, 2'd1, 8'h00);
    tick(); tick(); tick();
    check(busy == 0, "R4 slave blocked without cascade", busy, 0);
    // op 3 write has no effect
    drive(8'h1F, 0, 1, 2'd3, 8'hFF);
    tick();
    drive(8'h1F, 0, 1, 2'd2, 8'h01);
    tick();
    check(busy == 0, "R2 cascade write not yet seen", busy, 0);
    drive(8'h1F, 0, 0, 0, 0);
    tick();
    check(busy == 1 && chan == 0, "R4 slave granted via cascade", chan, 0);
    drive(8'hEE, 1, 0, 0, 0);
    tick();
    drive(8'hEE, 0, 0, 0, 0);
    tick();
    check(busy == 1 && chan == 1 && ack == 8'h02, "R3 ch1 beats ch5-7", chan, 1);
    drive(8'hEE, 1, 1, 2'd0, 8'h0C);  // done and mask ch4 together
    tick();
    drive(8'hEE, 0, 0, 0, 0);
    tick();
    check(busy == 1 && chan == 5, "R4 ch4 masked blocks slave", chan, 5);
    drive(8'h10, 1, 0, 0, 0);
    tick();
    drive(8'h10, 0, 1, 2'd0, 8'h04);
    tick(); tick(); tick();
    check(busy == 0, "R4 req on ch4 has no effect", busy, 0);
    drive(8'h00, 1, 0, 0, 0);
    tick(); tick();
    drive(8'h40, 0, 0, 0, 0);
    tick();
    check(busy == 1 && chan == 6, "R9 done while idle ignored", chan, 6);
    drive(8'h00, 1, 0, 0, 0);
    tick();

    // random phase, model compared every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[7:0] ^ lfsr[15:8], lfsr[3] & lfsr[9], lfsr[11] & lfsr[5] & lfsr[2],
            lfsr[13:12], {lfsr[6:0], lfsr[14]});
      tick();
    end
    drive(8'h00, 1, 0, 0, 0);
    tick(); tick();
    summary();
  end
endmodule